// File: doc/BRIEF.md
# UART Interrupt and Register Bank

This block is the software-visible face of a small serial port. It decodes word-aligned 32-bit reads and writes on a simple valid/write bus and keeps the interrupt bookkeeping: a pending-state vector, a mask, and a test port that forces pending bits. It also holds the control word, and a status word that mirrors the datapath's FIFO flags and tracks whether received data is waiting. Four level interrupt lines leave the block. Each line is the pending bit gated by its mask bit.

The serial engine, the FIFOs and the baud generator sit outside. They report pending events, flag levels and received bytes through input pins. The bank hands them the TX enable, the RX enable and the baud increment. A write to the transmit slot produces a one-cycle push strobe carrying the byte. A read of the receive slot, while reception is enabled, produces a one-cycle pop strobe. Several configuration words are stored and read back but change nothing: the parity, loopback and noise-filter bits, the FIFO control word, the override word and the timeout word.

Top module: `uart_regbank`

## Requirements
- R1: After a synchronous reset, every stored word reads zero and every interrupt line is low. The status word reads 0x34, with bits 2, 4 and 5 set.
- R2: Interrupt line k (bit 0 TX watermark, bit 1 RX watermark, bit 2 TX empty, bit 3 RX overflow) is high in the cycle after the clock edge where pending bit k and mask bit k are both 1. The mask lives at byte offset 0x04, bits 3:0.
- R3: A write to offset 0x00 clears each pending bit whose data bit is 1 and keeps every other pending bit. Reading 0x00 returns the pending bits in 3:0.
- R4: A write to offset 0x08 ORs data bits 3:0 into the pending bits. Reading 0x08 returns zero.
- R5: A high bit on `irq_set` sets that pending bit at the next edge. When it coincides with a clearing write to 0x00, the set wins.
- R6: The control word at 0x0C stores the bits under mask 0xFFFF03F7 and reads them back. Bit 0 drives `tx_enable`, bit 1 drives `rx_enable`, and bits 31:16 drive `baud_nco`.
- R7: Status bits 0 (TX full), 1 (RX full) and 2 (TX empty) at 0x10 show the values that `tx_full_in`, `rx_full_in` and `tx_empty_in` had at the previous clock edge.
- R8: A cycle with `rx_byte_valid` high stores `rx_byte`, which then reads at 0x14 in bits 7:0. The same edge clears status bit 4 (RX idle) and status bit 5 (RX empty).
- R9: A read of 0x14 while control bit 1 is set pulses `rx_pop` in that cycle and sets status bits 4 and 5 at the edge, unless a byte arrives at the same edge. With control bit 1 clear, the read has neither effect.
- R10: A write to 0x18 pulses `tx_push` in the same cycle, with `tx_byte` equal to data bits 7:0. Reading 0x18 returns zero.
- R11: Writes to 0x10, 0x14, 0x20 and 0x28 change nothing. Reading 0x28 returns zero.
- R12: An access whose byte address is outside 0x00 to 0x2C, or whose address bits 1:0 are not zero, reads zero and its write changes nothing.
- R13: The FIFO control word at 0x1C stores data bits 6:0. The override word at 0x24 and the timeout word at 0x2C store all 32 bits. Reading 0x20 returns `tx_level` in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of a read, zero otherwise |
| irq_set | input | 4 | Datapath event pulses, one per pending bit |
| tx_full_in | input | 1 | Transmit FIFO full flag |
| rx_full_in | input | 1 | Receive FIFO full flag |
| tx_empty_in | input | 1 | Transmit FIFO empty flag |
| rx_byte_valid | input | 1 | A received byte is presented |
| rx_byte | input | 8 | Received byte |
| tx_level | input | LVL_W (5) | Transmit FIFO fill level |
| irq | output | 4 | Level interrupt lines |
| tx_enable | output | 1 | Transmit enable |
| rx_enable | output | 1 | Receive enable |
| baud_nco | output | 16 | Baud increment value |
| tx_push | output | 1 | Strobe: byte written for transmission |
| tx_byte | output | 8 | Byte to transmit |
| rx_pop | output | 1 | Strobe: receive data consumed |

## Verification
A behavioural model is compared on every clock while three stimulus families run.

The first family is a directed sequence: a clearing write that collides with an event pulse, a forcing write, and mask changes. It separates a clear-wins bank from a set-wins bank, and an unmasked interrupt output from a masked one.

The second family covers the receive slot. Its reads happen with reception enabled and with it disabled, and some land in the same cycle as an arriving byte. These cases expose a re-arm that ignores the enable, and a wrong choice between the two updates when they coincide.

The third family is a long run of pseudo-random accesses, including misaligned and out-of-map addresses, mixed with random flag levels. It catches decode aliasing and wrong masks on the stored words.

// File: rtl/uart_regbank_pkg.sv
`timescale 1ns/1ps
package uart_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 12;
    localparam int NUM_IRQ  = 4;

    // Word indices of the register slots (byte offset = index * 4)
    localparam int RG_ISTATE   = 0;
    localparam int RG_IENABLE  = 1;
    localparam int RG_ITEST    = 2;
    localparam int RG_CTRL     = 3;
    localparam int RG_STATUS   = 4;
    localparam int RG_RXDATA   = 5;
    localparam int RG_TXDATA   = 6;
    localparam int RG_FIFOCTL  = 7;
    localparam int RG_FIFOSTAT = 8;
    localparam int RG_OVRD     = 9;
    localparam int RG_VAL      = 10;
    localparam int RG_TMO      = 11;

    // Pending-bit positions
    localparam int IRQ_TXWM    = 0;
    localparam int IRQ_RXWM    = 1;
    localparam int IRQ_TXEMPTY = 2;
    localparam int IRQ_RXOVF   = 3;

    // Control word fields
    localparam int CTRL_TXEN = 0;
    localparam int CTRL_RXEN = 1;
    localparam int NCO_LSB   = 16;
    localparam int NCO_W     = 16;
    localparam logic [DATA_W-1:0] CTRL_MASK    = 32'hFFFF_03F7;
    localparam logic [DATA_W-1:0] FIFOCTL_MASK = 32'h0000_007F;

    // Status word fields
    localparam int ST_W       = 6;
    localparam int ST_TXFULL  = 0;
    localparam int ST_RXFULL  = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_RSVD    = 3;
    localparam int ST_RXIDLE  = 4;
    localparam int ST_RXEMPTY = 5;
    localparam logic [ST_W-1:0] STATUS_RST = 6'b110100;

    typedef struct packed {
        logic                rd;
        logic                wr;
        logic [NUM_REGS-1:0] sel;
    } bus_dec_t;

    function automatic logic wr_hit(input bus_dec_t d, input int idx);
        return d.wr && d.sel[idx];
    endfunction

    function automatic logic rd_hit(input bus_dec_t d, input int idx);
        return d.rd && d.sel[idx];
    endfunction

endpackage

// File: rtl/uart_bus_decode.sv
`timescale 1ns/1ps
module uart_bus_decode
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output bus_dec_t          dec
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    assign dec.rd = valid && !write;
    assign dec.wr = valid && write;

    // Select lines: one per slot; out-of-map or misaligned hits none
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign dec.sel[i] = valid && aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
    import uart_regbank_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_we,
    input  logic         set_we,
    input  logic         en_we,
    input  logic [N-1:0] wval,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] state_q,
    output logic [N-1:0] en_q,
    output logic [N-1:0] irq
);
    logic [N-1:0] clr_vec, frc_vec;

    assign clr_vec = clr_we ? wval : '0;
    assign frc_vec = set_we ? wval : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            en_q    <= '0;
        end else begin
            // Hardware events and forcing writes take priority over clearing
            state_q <= (state_q & ~clr_vec) | frc_vec | hw_set;
            if (en_we) en_q <= wval;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_line
        assign irq[k] = state_q[k] & en_q[k];
    end
endmodule

// File: rtl/uart_status_reg.sv
`timescale 1ns/1ps
module uart_status_reg
    import uart_regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_full,
    input  logic            rx_full,
    input  logic            tx_empty,
    input  logic            rx_latch,
    input  logic            rx_rearm,
    output logic [ST_W-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_RST;
        end else begin
            status_q[ST_TXFULL]  <= tx_full;
            status_q[ST_RXFULL]  <= rx_full;
            status_q[ST_TXEMPTY] <= tx_empty;
            status_q[ST_RSVD]    <= 1'b0;
            if (rx_latch) begin
                status_q[ST_RXIDLE]  <= 1'b0;
                status_q[ST_RXEMPTY] <= 1'b0;
            end else if (rx_rearm) begin
                status_q[ST_RXIDLE]  <= 1'b1;
                status_q[ST_RXEMPTY] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_regbank.sv
`timescale 1ns/1ps
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LVL_W  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_IRQ-1:0]  irq_set,
    input  logic                tx_full_in,
    input  logic                rx_full_in,
    input  logic                tx_empty_in,
    input  logic                rx_byte_valid,
    input  logic [7:0]          rx_byte,
    input  logic [LVL_W-1:0]    tx_level,
    output logic [NUM_IRQ-1:0]  irq,
    output logic                tx_enable,
    output logic                rx_enable,
    output logic [NCO_W-1:0]    baud_nco,
    output logic                tx_push,
    output logic [7:0]          tx_byte,
    output logic                rx_pop
);
    bus_dec_t dec;

    logic [NUM_IRQ-1:0] istate_q, ien_q;
    logic [ST_W-1:0]    status_q;
    logic [DATA_W-1:0]  ctrl_q, fifo_q, ovrd_q, tmo_q;
    logic [7:0]         rxd_q;
    logic [DATA_W-1:0]  rb [NUM_REGS];

    uart_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .dec   (dec)
    );

    uart_irq_ctrl #(.N(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .clr_we  (wr_hit(dec, RG_ISTATE)),
        .set_we  (wr_hit(dec, RG_ITEST)),
        .en_we   (wr_hit(dec, RG_IENABLE)),
        .wval    (req_wdata[NUM_IRQ-1:0]),
        .hw_set  (irq_set),
        .state_q (istate_q),
        .en_q    (ien_q),
        .irq     (irq)
    );

    // Datapath strobes
    assign tx_push = wr_hit(dec, RG_TXDATA);
    assign tx_byte = req_wdata[7:0];
    assign rx_pop  = rd_hit(dec, RG_RXDATA) && ctrl_q[CTRL_RXEN];

    uart_status_reg u_stat (
        .clk      (clk),
        .rst      (rst),
        .tx_full  (tx_full_in),
        .rx_full  (rx_full_in),
        .tx_empty (tx_empty_in),
        .rx_latch (rx_byte_valid),
        .rx_rearm (rx_pop),
        .status_q (status_q)
    );

    // Stored configuration and receive data
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            fifo_q <= '0;
            ovrd_q <= '0;
            tmo_q  <= '0;
            rxd_q  <= '0;
        end else begin
            if (wr_hit(dec, RG_CTRL))    ctrl_q <= req_wdata & CTRL_MASK;
            if (wr_hit(dec, RG_FIFOCTL)) fifo_q <= req_wdata & FIFOCTL_MASK;
            if (wr_hit(dec, RG_OVRD))    ovrd_q <= req_wdata;
            if (wr_hit(dec, RG_TMO))     tmo_q  <= req_wdata;
            if (rx_byte_valid)           rxd_q  <= rx_byte;
        end
    end

    assign tx_enable = ctrl_q[CTRL_TXEN];
    assign rx_enable = ctrl_q[CTRL_RXEN];
    assign baud_nco  = ctrl_q[NCO_LSB +: NCO_W];

    // Readback: one value per slot, OR-combined through the one-hot select
    always_comb begin
        rb[RG_ISTATE]   = DATA_W'(istate_q);
        rb[RG_IENABLE]  = DATA_W'(ien_q);
        rb[RG_ITEST]    = '0;
        rb[RG_CTRL]     = ctrl_q;
        rb[RG_STATUS]   = DATA_W'(status_q);
        rb[RG_RXDATA]   = DATA_W'(rxd_q);
        rb[RG_TXDATA]   = '0;
        rb[RG_FIFOCTL]  = fifo_q;
        rb[RG_FIFOSTAT] = DATA_W'(tx_level);
        rb[RG_OVRD]     = ovrd_q;
        rb[RG_VAL]      = '0;
        rb[RG_TMO]      = tmo_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_hit(dec, i)) rd_data = rd_data | rb[i];
        end
    end
endmodule

// File: rtl/uart_regbank_chk.sv
`timescale 1ns/1ps
module uart_regbank_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        wdata_lo,
    input logic [3:0]        irq_set,
    input logic [3:0]        irq,
    input logic              tx_push,
    input logic              rx_pop,
    input logic              rx_enable,
    input logic              rx_byte_valid,
    input logic              tx_full_in,
    input logic [5:0]        status_q,
    input logic [3:0]        ien_q
);
    logic wr_state, wr_test, wr_en;
    assign wr_state = req_valid && req_write && (req_addr == ADDR_W'(0));
    assign wr_test  = req_valid && req_write && (req_addr == ADDR_W'(8));
    assign wr_en    = req_valid && req_write && (req_addr == ADDR_W'(4));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (irq == 4'b0 && status_q == 6'b110100));

    assert_w1c_all_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_state && wdata_lo == 4'hF && irq_set == 4'b0) |=> (irq == 4'b0));

    assert_test_force_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_test && wdata_lo == 4'hF) |=> (irq == ien_q));

    assert_event_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && irq_set != 4'b0) |=>
            ((irq & $past(irq_set & ien_q)) == $past(irq_set & ien_q)));

    assert_txfull_follow_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_q[0] == $past(tx_full_in)));

    assert_latch_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rx_byte_valid |=> (!status_q[4] && !status_q[5]));

    assert_pop_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> rx_enable);

    assert_pop_rearms_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_byte_valid) |=> (status_q[4] && status_q[5]));

    assert_push_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (req_valid && req_write));
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .wdata_lo      (req_wdata[3:0]),
    .irq_set       (irq_set),
    .irq           (irq),
    .tx_push       (tx_push),
    .rx_pop        (rx_pop),
    .rx_enable     (rx_enable),
    .rx_byte_valid (rx_byte_valid),
    .tx_full_in    (tx_full_in),
    .status_q      (status_q),
    .ien_q         (ien_q)
);

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
module tb_uart_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq_set = '0;
    logic        tx_full_in = 1'b0, rx_full_in = 1'b0, tx_empty_in = 1'b0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [4:0]  tx_level = '0;
    logic [3:0]  irq;
    logic        tx_enable, rx_enable, tx_push, rx_pop;
    logic [15:0] baud_nco;
    logic [7:0]  tx_byte;

    int n_vec = 0;
    int n_bad = 0;
    string phase = "R1 reset";

    always #10 clk = ~clk;

    uart_regbank dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .irq_set(irq_set), .tx_full_in(tx_full_in), .rx_full_in(rx_full_in),
        .tx_empty_in(tx_empty_in), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
        .tx_level(tx_level), .irq(irq), .tx_enable(tx_enable), .rx_enable(rx_enable),
        .baud_nco(baud_nco), .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop)
    );

    // Reference model state
    logic [3:0]  m_state = '0, m_en = '0;
    logic [31:0] m_ctrl = '0, m_fifo = '0, m_ovrd = '0, m_tmo = '0;
    logic [2:0]  m_flags = '0;
    logic        m_idle = 1'b1, m_empty = 1'b1;
    logic [7:0]  m_rxd = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s actual=%h expected=%h", phase, tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int idx);
        case (idx)
            0:  return {28'b0, m_state};
            1:  return {28'b0, m_en};
            3:  return m_ctrl;
            4:  return {26'b0, m_empty, m_idle, 1'b0, m_flags};
            5:  return {24'b0, m_rxd};
            7:  return m_fifo;
            8:  return {27'b0, tx_level};
            9:  return m_ovrd;
            11: return m_tmo;
            default: return 32'b0;
        endcase
    endfunction

    function automatic string tag_for(input int idx);
        case (idx)
            0:  return "R3 pending read";
            1:  return "R2 mask read";
            2:  return "R4 test slot read";
            3:  return "R6 control read";
            4:  return "R7 status read";
            5:  return "R8 rx data read";
            6:  return "R10 tx slot read";
            7:  return "R13 fifo ctrl read";
            8:  return "R13 fifo level read";
            9:  return "R13 override read";
            10: return "R11 value slot read";
            11: return "R13 timeout read";
            default: return "R12 unmapped read";
        endcase
    endfunction

    // One clock of stimulus: combinational checks, model update, registered checks
    task automatic step();
        int idx;
        logic wr, rd, e_push, e_pop;
        logic [3:0] n_state;
        idx = int'(req_addr >> 2);
        if (req_addr[1:0] != 2'b00 || idx > 11) idx = 15;
        wr = req_valid && req_write;
        rd = req_valid && !req_write;
        #2;
        chk(tag_for(idx), rd_data, rd ? model_read(idx) : 32'b0);
        e_push = wr && idx == 6;
        e_pop  = rd && idx == 5 && m_ctrl[1];
        chk("R10 tx_push", 32'(tx_push), 32'(e_push));
        if (e_push) chk("R10 tx_byte", 32'(tx_byte), 32'(req_wdata[7:0]));
        chk("R9 rx_pop", 32'(rx_pop), 32'(e_pop));
        @(posedge clk);
        if (rst) begin
            m_state = '0; m_en = '0; m_ctrl = '0; m_fifo = '0; m_ovrd = '0; m_tmo = '0;
            m_flags = '0; m_idle = 1'b1; m_empty = 1'b1; m_rxd = '0;
        end else begin
            n_state = m_state;
            if (wr && idx == 0) n_state = n_state & ~req_wdata[3:0];
            if (wr && idx == 2) n_state = n_state | req_wdata[3:0];
            n_state = n_state | irq_set;
            m_state = n_state;
            if (wr && idx == 1)  m_en   = req_wdata[3:0];
            if (wr && idx == 3)  m_ctrl = req_wdata & 32'hFFFF_03F7;
            if (wr && idx == 7)  m_fifo = req_wdata & 32'h0000_007F;
            if (wr && idx == 9)  m_ovrd = req_wdata;
            if (wr && idx == 11) m_tmo  = req_wdata;
            m_flags = {tx_empty_in, rx_full_in, tx_full_in};
            if (rx_byte_valid) begin
                m_idle = 1'b0; m_empty = 1'b0; m_rxd = rx_byte;
            end else if (e_pop) begin
                m_idle = 1'b1; m_empty = 1'b1;
            end
        end
        @(negedge clk);
        chk("R2 irq lines", 32'(irq), 32'(m_state & m_en));
        chk("R6 tx_enable", 32'(tx_enable), 32'(m_ctrl[0]));
        chk("R6 rx_enable", 32'(rx_enable), 32'(m_ctrl[1]));
        chk("R6 baud_nco", 32'(baud_nco), 32'(m_ctrl[31:16]));
        req_valid = 1'b0; req_write = 1'b0; irq_set = '0; rx_byte_valid = 1'b0;
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        step();
    endtask

    task automatic rd_reg(input logic [5:0] a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        step();
    endtask

    task automatic rd_all();
        for (int i = 0; i < 16; i++) rd_reg(6'(i * 4));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL [watchdog] run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step(); step();
        rst = 1'b0;
        // R1: reset values, R12: out-of-map slots
        rd_all();
        rd_reg(6'h01);

        phase = "R6 control";
        wr_reg(6'h0C, 32'hABCD_FFFF);
        rd_reg(6'h0C);

        phase = "R4 force";
        wr_reg(6'h04, 32'hFFFF_FFFF);
        wr_reg(6'h08, 32'h0000_0005);
        rd_reg(6'h08);
        rd_reg(6'h00);

        phase = "R3 clear";
        wr_reg(6'h00, 32'h0000_0001);
        rd_reg(6'h00);

        phase = "R2 mask";
        wr_reg(6'h04, 32'h0000_0003);
        wr_reg(6'h08, 32'h0000_000A);
        wr_reg(6'h04, 32'h0000_000F);

        phase = "R5 event beats clear";
        irq_set = 4'b1001;
        wr_reg(6'h00, 32'hFFFF_FFFF);
        rd_reg(6'h00);
        irq_set = 4'b0110;
        step();

        phase = "R7 flags";
        tx_full_in = 1'b1; tx_empty_in = 1'b0; rx_full_in = 1'b1;
        rd_reg(6'h10);
        rd_reg(6'h10);
        tx_full_in = 1'b0; tx_empty_in = 1'b1;
        rd_reg(6'h10);

        phase = "R8 rx latch";
        rx_byte_valid = 1'b1; rx_byte = 8'h5A;
        step();
        rd_reg(6'h10);

        phase = "R9 rearm enabled";
        rd_reg(6'h14);
        rd_reg(6'h10);
        rx_byte_valid = 1'b1; rx_byte = 8'hC3;
        rd_reg(6'h14);
        rd_reg(6'h10);

        phase = "R9 rearm disabled";
        wr_reg(6'h0C, 32'h0000_0001);
        rd_reg(6'h14);
        rd_reg(6'h10);

        phase = "R10 transmit";
        wr_reg(6'h18, 32'h1234_56A7);
        rd_reg(6'h18);

        phase = "R11 read-only slots";
        wr_reg(6'h10, 32'hFFFF_FFFF);
        wr_reg(6'h14, 32'hFFFF_FFFF);
        wr_reg(6'h20, 32'hFFFF_FFFF);
        wr_reg(6'h28, 32'hFFFF_FFFF);
        rd_all();

        phase = "R12 unmapped";
        wr_reg(6'h30, 32'hFFFF_FFFF);
        wr_reg(6'h3C, 32'hFFFF_FFFF);
        wr_reg(6'h0D, 32'hFFFF_FFFF);
        wr_reg(6'h02, 32'hFFFF_FFFF);
        rd_all();

        phase = "R13 stored words";
        tx_level = 5'h13;
        wr_reg(6'h1C, 32'hFFFF_FFFF);
        wr_reg(6'h24, 32'hDEAD_BEEF);
        wr_reg(6'h2C, 32'h0BAD_F00D);
        rd_all();

        phase = "random";
        for (int k = 0; k < 2000; k++) begin
            int sel;
            tx_full_in  = 1'($urandom);
            rx_full_in  = 1'($urandom);
            tx_empty_in = 1'($urandom);
            tx_level    = 5'($urandom);
            irq_set       = ($urandom % 5 == 0) ? 4'($urandom) : 4'b0;
            rx_byte_valid = ($urandom % 6 == 0);
            rx_byte       = 8'($urandom);
            if ($urandom % 4 != 0) begin
                sel = $urandom % 16;
                req_valid = 1'b1;
                req_write = 1'($urandom);
                req_addr  = {4'(sel), ($urandom % 8 == 0) ? 2'b01 : 2'b00};
                req_wdata = $urandom;
            end
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule